// File: doc/BRIEF.md
# Three-Wire Register Access Master

This block is a serial master for reading and writing 8-bit registers in up to two external slave chips. The slaves share one serial clock and one bidirectional data line. Each slave has its own active-high chip select. A host presents a command: a slave choice, a 7-bit register address, a read/write flag and 8 bits of write data. The block then runs exactly one 16-bit frame on the link and reports completion with a one-cycle done pulse. For a read, the done pulse comes with the byte returned by the slave.

The serial clock is derived from the system clock. A parameter sets the length of each clock half-period in system cycles. The master changes its data bit only while the serial clock falls. During a read, it stops driving the line after the read/write bit, and it samples the slave's reply on the falling edges of the serial clock. The bidirectional line is presented as three separate signals: output value, output enable and input value. The pad's tristate buffer joins them at the chip edge.

Top module: `tw_link_master`

## Requirements
- R1: A frame carries 16 bits, most significant bit first. Frame bits 15:9 hold the register address, bit 8 holds the read/write flag (0 = write, 1 = read), and bits 7:0 hold the data byte.
- R2: `cmd_sel` = 0 raises only `csel_a` and `cmd_sel` = 1 raises only `csel_b`. The two selects are never high together, and both are low between frames.
- R3: `sclk` rests low and only toggles while a select is high. The select is high for exactly HALF_DIV system cycles before the first rising edge of `sclk`. Every `sclk` half-period lasts HALF_DIV cycles, and each frame has exactly 16 rising edges.
- R4: While `sclk` is high, the master keeps `sda_out` constant. New bits appear only on falling edges, except the first bit, which appears together with the rising select.
- R5: In a write, `sda_oe` is high at all 16 rising edges of `sclk`.
- R6: In a read, `sda_oe` is high at the first 8 rising edges and low from the falling edge that ends the read/write bit until the frame ends. `sda_in` is sampled on the last 8 falling edges, and the sampled bits form `rdata` MSB first.
- R7: The last falling edge of `sclk` occurs 32·HALF_DIV cycles after the command is accepted. The select drops HALF_DIV cycles later. `done` pulses for exactly that one cycle. `rdata` is valid from the pulse until the next command and reads 0 after a write.
- R8: `busy` rises the cycle after a command is accepted and falls with `done`. A command presented while `busy` is high is ignored.
- R9: `sda_oe` is low whenever no select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_sel | input | 1 | Slave choice: 0 = `csel_a`, 1 = `csel_b` |
| cmd_addr | input | 7 | Register address |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | 8 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read from the slave |
| sclk | output | 1 | Serial clock |
| csel_a | output | 1 | Active-high select of slave A |
| csel_b | output | 1 | Active-high select of slave B |
| sda_out | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable |
| sda_in | input | 1 | Data line input value |

## Verification
A command is accepted at one clock edge. From that edge, the select rises at once, the first `sclk` rise comes HALF_DIV cycles later and the last fall comes 32·HALF_DIV cycles later. `done`, the falling select and valid `rdata` all arrive at 33·HALF_DIV cycles. The bench drives commands half a cycle before the edge and counts every later falling system-clock edge. It therefore expects `done` on its 33·HALF_DIV+1-th sample and measures setup, hold and select-high spans as counts of those samples. A slave model in the bench decodes the frame on `sclk` rising edges and drives its reply half a system cycle after each rise, so the reply bit is stable long before the master samples it.

// File: rtl/tw_pkg.sv
// Package: constants and types shared by the three-wire master.
// Assumes: one frame = address field, one read/write bit, one data byte.
package tw_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // no frame, selects low
        ST_SETUP,  // select high, clock still low
        ST_HIGH,   // serial clock high half of a bit
        ST_LOW,    // serial clock low half between bits
        ST_HOLD    // after last fall, before select drops
    } tw_state_t;

endpackage

// File: rtl/tw_tick.sv
// Module: half-period tick generator.
// Emits one tick every HALF_DIV system cycles while run is high.
// Assumes: run stays high for the whole frame, and the count restarts when
// run drops so that every frame begins with a full half-period.
module tw_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    generate
        if (HALF_DIV == 1) begin : g_every
            // Divider of one: every running cycle ends a half-period
            assign tick = run;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;

            // Count system cycles within the current half-period
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/tw_shift.sv
// Module: transmit and receive shift registers.
// Holds the outgoing frame with the current bit at the top, and collects
// sampled reply bits MSB first.
// Assumes: load, shift and capture come from the sequencer; shift and
// capture may occur in the same cycle.
module tw_shift #(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    input  logic               capture,
    input  logic               sda_in,
    output logic               tx_bit,
    output logic [DATA_W-1:0]  rx_data
);
    logic [FRAME_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;

    // Outgoing frame: load on accept, advance one bit per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= frame_in;
        end else if (shift) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Reply byte: clear on accept, shift in one sample per read falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[DATA_W-2:0], sda_in};
        end
    end

    assign tx_bit  = tx_q[FRAME_W-1];
    assign rx_data = rx_q;

endmodule

// File: rtl/tw_seq.sv
// Module: frame sequencer.
// Walks setup, 16 clock periods and hold; drives the clock, the selects, the
// output enable and the done pulse; tells the shifter when to load, shift and
// sample.
// Assumes: tick marks the last cycle of each half-period.
module tw_seq
    import tw_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int FRAME_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_sel,
    input  logic       cmd_rd,
    input  logic       tick,
    output logic       run,
    output logic       busy,
    output logic       done,
    output logic       sclk,
    output logic [1:0] csel,
    output logic       oe,
    output logic       load,
    output logic       shift,
    output logic       capture
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] RW_BIT   = BIT_W'(ADDR_W);

    tw_state_t        state;
    logic [BIT_W-1:0] bitn;
    logic             rd_q;
    logic             sclk_q;
    logic [1:0]       cs_q;
    logic             oe_q;
    logic             done_q;

    // Strobes for the shifter, all aligned to a falling clock edge
    assign load    = (state == ST_IDLE) && cmd_valid;
    assign shift   = (state == ST_HIGH) && tick && (bitn != LAST_BIT);
    assign capture = (state == ST_HIGH) && tick && rd_q && (bitn > RW_BIT);

    // Frame state, clock level, selects, output enable and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitn   <= '0;
            rd_q   <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= 2'b00;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        state         <= ST_SETUP;
                        bitn          <= '0;
                        rd_q          <= cmd_rd;
                        cs_q[cmd_sel] <= 1'b1;
                        oe_q          <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        state  <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        if (bitn == LAST_BIT) begin
                            state <= ST_HOLD;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            state <= ST_LOW;
                            if (rd_q && (bitn >= RW_BIT)) begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        state  <= ST_HIGH;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_q   <= 2'b00;
                        oe_q   <= 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run  = (state != ST_IDLE);
    assign busy = (state != ST_IDLE);
    assign done = done_q;
    assign sclk = sclk_q;
    assign csel = cs_q;
    assign oe   = oe_q;

    // R2: never both selects at once
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_q[0] && cs_q[1]));

    // R2: slave B select rises only for a command that chose slave B
    p_select_b_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q[1]) |-> $past(cmd_sel));

    // R3: serial clock only high inside a selected frame
    p_clk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> (|cs_q));

    // R3: a rising clock edge always follows a cycle with the select already high
    p_select_before_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $past(|cs_q));

    // R6: line released throughout the read data phase
    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && ((state == ST_HIGH) || (state == ST_LOW)) && (bitn > RW_BIT))
            |-> !oe_q);

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: a command during a frame does not alter the latched direction
    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && cmd_valid) |=> $stable(rd_q));

    // R9: line never driven while idle
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == 2'b00) |-> !oe_q);

endmodule

// File: rtl/tw_link_master.sv
// Module: three-wire register access master (top).
// Accepts one command at a time and runs one 16-bit frame per command on a
// shared clock/data link with two active-high selects.
// Assumes: the pad ring joins sda_out, sda_oe and sda_in into one tristate pin.
module tw_link_master #(
    parameter int HALF_DIV = 2,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_sel,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_rd,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              csel_a,
    output logic              csel_b,
    output logic              sda_out,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;

    logic             run;
    logic             tick;
    logic             load;
    logic             shift;
    logic             capture;
    logic             tx_bit;
    logic [1:0]       csel;
    logic [FRAME_W-1:0] frame;

    // Frame image: address, direction bit, data byte
    assign frame = {cmd_addr, cmd_rd, cmd_wdata};

    tw_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    tw_seq #(
        .ADDR_W  (ADDR_W),
        .FRAME_W (FRAME_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_sel   (cmd_sel),
        .cmd_rd    (cmd_rd),
        .tick      (tick),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .sclk      (sclk),
        .csel      (csel),
        .oe        (sda_oe),
        .load      (load),
        .shift     (shift),
        .capture   (capture)
    );

    tw_shift #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame),
        .shift    (shift),
        .capture  (capture),
        .sda_in   (sda_in),
        .tx_bit   (tx_bit),
        .rx_data  (rdata)
    );

    assign csel_a  = csel[0];
    assign csel_b  = csel[1];
    assign sda_out = sda_oe ? tx_bit : 1'b0;

    // R4: data line steady for the whole high half of the serial clock
    p_line_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sda_out));

endmodule

// File: tb/tw_link_master_bench.sv
// Bench: sweeps both slaves, both directions and several address/data
// patterns; a behavioural slave decodes frames and answers reads.
module tw_link_master_bench;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_sel = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic       cmd_rd = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic       busy, done, sclk, csel_a, csel_b, sda_out, sda_oe;
    logic [7:0] rdata;
    logic       sda_in = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tw_link_master #(.HALF_DIV(H)) u_tw_link_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rdata(rdata), .sclk(sclk),
        .csel_a(csel_a), .csel_b(csel_b), .sda_out(sda_out), .sda_oe(sda_oe),
        .sda_in(sda_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reply(input logic sel, input logic [6:0] a);
        return 8'({1'b0, a} * 8'd5) ^ (sel ? 8'h96 : 8'h3C);
    endfunction

    // Slave model and link monitor, sampled on falling system-clock edges
    logic        prev_sclk = 1'b0, prev_cs = 1'b0, prev_sda = 1'b0;
    int          nrise = 0, oe_hi = 0, cs_cyc = 0, setup_cyc = 0, hold_cyc = 0;
    int          frames_seen = 0, stab_viol = 0, idle_viol = 0, rise_viol = 0;
    logic [15:0] mbits = '0;
    logic [1:0]  cs_seen = '0;
    logic        done_at_end = 1'b0, rw_seen = 1'b0;
    logic [7:0]  slave_byte = '0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ((csel_a | csel_b) && !prev_cs) begin
                    nrise = 0; oe_hi = 0; cs_cyc = 0; setup_cyc = 0;
                    hold_cyc = 0; mbits = '0; cs_seen = '0; sda_in = 1'b1;
                end
                if (csel_a | csel_b) begin
                    cs_cyc++;
                    cs_seen = cs_seen | {csel_b, csel_a};
                    if (!sclk && nrise == 0) setup_cyc++;
                    if (!sclk && nrise == 16) hold_cyc++;
                end
                if (sclk && !(csel_a | csel_b)) rise_viol++;
                if (sclk && prev_sclk && (sda_out != prev_sda)) stab_viol++;
                if (!(csel_a | csel_b) && sda_oe) idle_viol++;
                if (sclk && !prev_sclk) begin
                    mbits = {mbits[14:0], sda_out};
                    oe_hi += int'(sda_oe);
                    if (nrise == 7) begin
                        rw_seen = mbits[0];
                        slave_byte = reply(csel_b, mbits[7:1]);
                    end
                    if (nrise >= 8 && rw_seen) sda_in = slave_byte[15 - nrise];
                    nrise++;
                end
                if (prev_cs && !(csel_a | csel_b)) begin
                    done_at_end = done;
                    frames_seen++;
                end
            end
            prev_cs = csel_a | csel_b;
            prev_sclk = sclk;
            prev_sda = sda_out;
        end
    end

    task automatic run_cmd(input logic sel, input logic [6:0] a, input logic rd,
                           input logic [7:0] wd, input bit poke);
        int f0;
        int lat;
        @(negedge clk); #1;
        cmd_sel = sel; cmd_addr = a; cmd_rd = rd; cmd_wdata = wd; cmd_valid = 1'b1;
        f0 = frames_seen;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        lat = 1;
        while (frames_seen == f0 && lat < 2000) begin
            if (lat == 5) chk("R8 busy during frame", int'(busy), 1);
            if (poke && (lat == 10 || lat == 33 * H)) begin
                cmd_valid = 1'b1; cmd_sel = ~sel; cmd_addr = ~a;
                cmd_rd = ~rd; cmd_wdata = ~wd;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk); #1;
            lat++;
        end
        cmd_valid = 1'b0;
        // done sample: accept edge plus 33*H cycles, seen one falling edge later
        chk("R7 done latency", lat, 33 * H + 1);
        chk("R7 done with select fall", int'(done_at_end), 1);
        chk("R8 busy low at done", int'(busy), 0);
        chk("R3 setup half-period", setup_cyc, H);
        chk("R3 hold half-period", hold_cyc, H);
        chk("R3 rising edges", nrise, 16);
        chk("R3 select high span", cs_cyc, 33 * H);
        chk("R2 chosen select", int'(cs_seen), sel ? 2 : 1);
        if (!rd) begin
            chk("R1 write frame", int'(mbits), int'({a, 1'b0, wd}));
            chk("R5 write drive count", oe_hi, 16);
            chk("R7 rdata after write", int'(rdata), 0);
        end else begin
            chk("R1 read header", int'(mbits[15:8]), int'({a, 1'b1}));
            chk("R6 read drive count", oe_hi, 8);
            chk("R6 read data", int'(rdata), int'(reply(sel, a)));
        end
        @(negedge clk); #1;
        chk("R7 done single cycle", int'(done), 0);
        if (poke) begin
            repeat (4) begin
                @(negedge clk); #1;
                chk("R8 no frame from ignored command",
                    int'(csel_a | csel_b | busy), 0);
            end
            chk("R8 frame count", frames_seen, f0 + 1);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R2 reset selects", int'({csel_b, csel_a}), 0);
        chk("R3 reset clock", int'(sclk), 0);
        chk("R9 reset enable", int'(sda_oe), 0);
        chk("R8 reset busy", int'(busy), 0);
        chk("R7 reset done", int'(done), 0);
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 2; r++) begin
                for (int i = 0; i < 6; i++) begin
                    logic [6:0] a;
                    logic [7:0] d;
                    a = (i == 0) ? 7'h00 : (i == 5) ? 7'h7F : 7'((i * 37 + 11) & 127);
                    d = (i == 0) ? 8'hFF : (i == 5) ? 8'h00 : 8'((i * 53) ^ 8'hA5);
                    run_cmd(s[0], a, r[0], d, i == 2);
                end
            end
        end
        chk("R4 line steady while clock high", stab_viol, 0);
        chk("R9 released while idle", idle_viol, 0);
        chk("R3 clock only inside frame", rise_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule